// File: doc/BRIEF.md
# Single-Cycle 8-bit Accumulator Processor

This block is a small 8-bit processor that executes one 16-bit instruction per clock. It has no program counter and no instruction memory. An external controller or a testbench presents each instruction on a parallel bus together with a valid flag. The block decodes it, runs it through a combinational ALU, and commits the result at the next rising clock edge. The machine state is one accumulator, a four-entry register file whose entry 0 always reads zero, and a registered 8-bit output port.

Every instruction names at most one register operand; the accumulator is the implied second operand and the usual destination. Immediates come in two kinds. Loads and immediate adds sign-extend a 6-bit constant. The immediate AND uses all eight raw bits. Shifts are logical and take their amount from the low three bits of a register or of the immediate.

The instruction input follows valid/ready rules. A word is consumed on any rising edge where both `instr_valid` and `instr_ready` are high. `instr_ready` is low only while reset is asserted, so the block never applies back-pressure during normal operation. A producer may hold `instr_valid` low for any number of cycles, and the machine state then stays unchanged.

Top module: `accpu_top`

## Requirements
- R1: An active-high synchronous reset clears the accumulator, registers x1..x3 and `out_data` to 0x00. Reset takes priority over a valid instruction presented in the same cycle. `instr_ready` is 0 while `rst` is 1 and 1 otherwise.
- R2: In a cycle with `instr_valid` low, the accumulator, the register file and `out_data` keep their values, whatever the instruction bus carries.
- R3: Opcode 0x4 (store) copies the accumulator into the register selected by instr[11:10] and leaves the accumulator unchanged. A store that selects x0 is dropped, and x0 always reads 0x00.
- R4: Opcode 0x1 loads the accumulator with instr[5:0] sign-extended (bit 5 copied into bits 7:6). Immediate bits 7:6 have no effect on this opcode.
- R5: Opcode 0x3 adds the sign-extended 6-bit immediate to the accumulator, modulo 256.
- R6: Opcode 0x2 adds the selected register to the accumulator, and opcode 0x5 subtracts it from the accumulator. Both operations wrap modulo 256.
- R7: Opcodes 0x6, 0x7 and 0x8 replace the accumulator with its bitwise AND, OR and XOR, respectively, with the selected register.
- R8: Opcode 0x9 ANDs the accumulator with the raw 8-bit immediate instr[7:0], without sign extension. Opcode 0xA replaces the accumulator with its bitwise complement.
- R9: Opcode 0x0 sets the accumulator to 0x01 when the accumulator is less than the selected register under signed two's-complement comparison, and to 0x00 otherwise. Equal values give 0x00.
- R10: Opcodes 0xB and 0xC shift the accumulator logically left and right by register bits [2:0]. Opcodes 0xD and 0xE do the same by instr[2:0]. Vacated bits fill with zero, and higher bits of the shift amount are ignored.
- R11: Opcode 0xF copies the accumulator into `out_data`, where it is visible after the committing edge. No other opcode changes `out_data`, and opcode 0xF leaves the accumulator unchanged.
- R12: The opcode is taken from instr[15:12] and the register select from instr[11:10]. The reserved bits instr[9:8] have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all state changes on the rising edge |
| rst | input | 1 | Active-high synchronous reset |
| instr_valid | input | 1 | Instruction bus carries a word to execute |
| instr | input | 16 | Instruction word: opcode, register select, reserved, immediate |
| instr_ready | output | 1 | Block accepts a word this cycle (low only during reset) |
| out_data | output | 8 | Registered output port, loaded by the output opcode |

## Verification
The case where two functions fall in the same cycle is a reset edge that also carries a valid instruction. The directed test first fills the accumulator, a register and the output port with nonzero values. It then raises `rst` and, in the same cycle, presents a valid store into x3. After reset is released, the bench reads back the output port, the accumulator and both registers through ordinary instructions and expects zero everywhere. This shows that reset overrode the write. A second case pairs an output opcode and a store with `instr_valid` low, and checks that neither reaches the port or the register file.

// File: rtl/accpu_pkg.sv
package accpu_pkg;

  localparam int DATA_W   = 8;
  localparam int INSTR_W  = 16;
  localparam int NREGS    = 4;
  localparam int SEL_W    = $clog2(NREGS);
  localparam int OPC_W    = 4;
  localparam int IMM_W    = 8;
  localparam int SEXT_W   = 6;
  localparam int SHAMT_W  = 3;

  localparam int OPC_LO   = INSTR_W - OPC_W;
  localparam int SEL_LO   = OPC_LO - SEL_W;
  localparam int RSV_LO   = IMM_W;

  typedef enum logic [OPC_W-1:0] {
    OP_SLT = 4'h0, OP_LDI = 4'h1, OP_ADD = 4'h2, OP_ADI = 4'h3,
    OP_STA = 4'h4, OP_SUB = 4'h5, OP_AND = 4'h6, OP_OR  = 4'h7,
    OP_XOR = 4'h8, OP_ANI = 4'h9, OP_NOT = 4'hA, OP_SLL = 4'hB,
    OP_SRL = 4'hC, OP_SLI = 4'hD, OP_SRI = 4'hE, OP_OUT = 4'hF
  } opcode_e;

  typedef enum logic [3:0] {
    FN_SLT, FN_PASSB, FN_ADD, FN_SUB, FN_AND,
    FN_OR, FN_XOR, FN_NOT, FN_SHL, FN_SHR
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e fn;
    logic    use_imm;
    logic    acc_we;
    logic    rf_we;
    logic    port_we;
  } ctrl_t;

endpackage

// File: rtl/accpu_decode.sv
module accpu_decode
  import accpu_pkg::*;
#(
  parameter int D_W = DATA_W
) (
  input  logic               valid,
  input  logic [OPC_W-1:0]   opc,
  input  logic [IMM_W-1:0]   imm_field,
  output ctrl_t              ctrl,
  output logic [D_W-1:0]     imm_opnd
);

  localparam int EXT_W = D_W - SEXT_W;

  logic [D_W-1:0] imm_sext;
  logic [D_W-1:0] imm_raw;
  logic           pick_sext;
  ctrl_t          raw_ctrl;

  assign imm_sext = {{EXT_W{imm_field[SEXT_W-1]}}, imm_field[SEXT_W-1:0]};
  assign imm_raw  = D_W'(imm_field);

  always_comb begin
    raw_ctrl  = '{fn: FN_PASSB, use_imm: 1'b0, acc_we: 1'b0,
                  rf_we: 1'b0, port_we: 1'b0};
    pick_sext = 1'b0;
    unique case (opcode_e'(opc))
      OP_SLT: begin raw_ctrl.fn = FN_SLT;   raw_ctrl.acc_we = 1'b1; end
      OP_LDI: begin
        raw_ctrl.fn = FN_PASSB; raw_ctrl.use_imm = 1'b1;
        raw_ctrl.acc_we = 1'b1; pick_sext = 1'b1;
      end
      OP_ADD: begin raw_ctrl.fn = FN_ADD;   raw_ctrl.acc_we = 1'b1; end
      OP_ADI: begin
        raw_ctrl.fn = FN_ADD; raw_ctrl.use_imm = 1'b1;
        raw_ctrl.acc_we = 1'b1; pick_sext = 1'b1;
      end
      OP_STA: begin raw_ctrl.rf_we = 1'b1; end
      OP_SUB: begin raw_ctrl.fn = FN_SUB;   raw_ctrl.acc_we = 1'b1; end
      OP_AND: begin raw_ctrl.fn = FN_AND;   raw_ctrl.acc_we = 1'b1; end
      OP_OR:  begin raw_ctrl.fn = FN_OR;    raw_ctrl.acc_we = 1'b1; end
      OP_XOR: begin raw_ctrl.fn = FN_XOR;   raw_ctrl.acc_we = 1'b1; end
      OP_ANI: begin
        raw_ctrl.fn = FN_AND; raw_ctrl.use_imm = 1'b1; raw_ctrl.acc_we = 1'b1;
      end
      OP_NOT: begin raw_ctrl.fn = FN_NOT;   raw_ctrl.acc_we = 1'b1; end
      OP_SLL: begin raw_ctrl.fn = FN_SHL;   raw_ctrl.acc_we = 1'b1; end
      OP_SRL: begin raw_ctrl.fn = FN_SHR;   raw_ctrl.acc_we = 1'b1; end
      OP_SLI: begin
        raw_ctrl.fn = FN_SHL; raw_ctrl.use_imm = 1'b1; raw_ctrl.acc_we = 1'b1;
      end
      OP_SRI: begin
        raw_ctrl.fn = FN_SHR; raw_ctrl.use_imm = 1'b1; raw_ctrl.acc_we = 1'b1;
      end
      OP_OUT: begin raw_ctrl.port_we = 1'b1; end
      default: ;
    endcase
  end

  // Write enables are qualified by the handshake here, so nothing downstream
  // needs to know about valid.
  always_comb begin
    ctrl         = raw_ctrl;
    ctrl.acc_we  = raw_ctrl.acc_we  & valid;
    ctrl.rf_we   = raw_ctrl.rf_we   & valid;
    ctrl.port_we = raw_ctrl.port_we & valid;
  end

  assign imm_opnd = pick_sext ? imm_sext : imm_raw;

endmodule

// File: rtl/accpu_alu.sv
module accpu_alu
  import accpu_pkg::*;
#(
  parameter int D_W   = DATA_W,
  parameter int SH_W  = SHAMT_W
) (
  input  alu_fn_e          fn,
  input  logic [D_W-1:0]   a,
  input  logic [D_W-1:0]   b,
  output logic [D_W-1:0]   y
);

  logic [SH_W-1:0] shamt;
  logic            less;

  assign shamt = b[SH_W-1:0];
  assign less  = $signed(a) < $signed(b);

  always_comb begin
    unique case (fn)
      FN_SLT:   y = {{(D_W-1){1'b0}}, less};
      FN_PASSB: y = b;
      FN_ADD:   y = a + b;
      FN_SUB:   y = a - b;
      FN_AND:   y = a & b;
      FN_OR:    y = a | b;
      FN_XOR:   y = a ^ b;
      FN_NOT:   y = ~a;
      FN_SHL:   y = a << shamt;
      FN_SHR:   y = a >> shamt;
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/accpu_regfile.sv
module accpu_regfile
  import accpu_pkg::*;
#(
  parameter int D_W = DATA_W,
  parameter int N   = NREGS,
  localparam int A_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [A_W-1:0]  addr,
  input  logic [D_W-1:0]  wdata,
  output logic [D_W-1:0]  rdata
);

  logic [D_W-1:0] entry [N];

  // Entry 0 is a constant; only entries 1..N-1 hold state, so a write
  // addressed to entry 0 has nowhere to land.
  for (genvar i = 0; i < N; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign entry[i] = '0;
    end else begin : g_store
      logic [D_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (we && addr == A_W'(i))
          q <= wdata;
      end
      assign entry[i] = q;
    end
  end

  assign rdata = entry[addr];

endmodule

// File: rtl/accpu_top.sv
module accpu_top
  import accpu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_valid,
  input  logic [INSTR_W-1:0]  instr,
  output logic                instr_ready,
  output logic [DATA_W-1:0]   out_data
);

  logic [OPC_W-1:0]  opc;
  logic [SEL_W-1:0]  sel;
  logic [IMM_W-1:0]  imm_field;
  logic              unused_rsvd;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] imm_opnd;
  logic [DATA_W-1:0] rs_data;
  logic [DATA_W-1:0] alu_b;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] port_q;
  logic              take;

  assign opc         = instr[INSTR_W-1:OPC_LO];
  assign sel         = instr[OPC_LO-1:SEL_LO];
  assign imm_field   = instr[IMM_W-1:0];
  assign unused_rsvd = ^instr[SEL_LO-1:RSV_LO];

  assign instr_ready = ~rst;
  assign take        = instr_valid & instr_ready;

  accpu_decode #(.D_W(DATA_W)) u_decode (
    .valid     (take),
    .opc       (opc),
    .imm_field (imm_field),
    .ctrl      (ctrl),
    .imm_opnd  (imm_opnd)
  );

  accpu_regfile #(.D_W(DATA_W), .N(NREGS)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (ctrl.rf_we),
    .addr  (sel),
    .wdata (acc_q),
    .rdata (rs_data)
  );

  assign alu_b = ctrl.use_imm ? imm_opnd : rs_data;

  accpu_alu #(.D_W(DATA_W), .SH_W(SHAMT_W)) u_alu (
    .fn (ctrl.fn),
    .a  (acc_q),
    .b  (alu_b),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      port_q <= '0;
    end else begin
      if (ctrl.acc_we)  acc_q  <= alu_y;
      if (ctrl.port_we) port_q <= acc_q;
    end
  end

  assign out_data = port_q;

endmodule

// File: rtl/accpu_checks.sv
module accpu_checks
  import accpu_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                instr_valid,
  input logic [INSTR_W-1:0]  instr,
  input logic                instr_ready,
  input logic [DATA_W-1:0]   out_data,
  input logic [DATA_W-1:0]   acc_q
);

  localparam logic [OPC_W-1:0] C_SLT = 4'h0;
  localparam logic [OPC_W-1:0] C_LDI = 4'h1;
  localparam logic [OPC_W-1:0] C_STA = 4'h4;
  localparam logic [OPC_W-1:0] C_OUT = 4'hF;

  logic [OPC_W-1:0] opc;
  logic             rst_d;

  assign opc = instr[INSTR_W-1:OPC_LO];

  always_ff @(posedge clk) rst_d <= rst;

  // R1: state is zero on the edge after a reset edge
  always @(posedge clk) begin
    if (rst_d == 1'b1)
      a_r1_reset_clears: assert (acc_q == '0 && out_data == '0);
    if (rst == 1'b1)
      a_r1_not_ready_in_reset: assert (instr_ready == 1'b0);
  end

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> ($stable(acc_q) && $stable(out_data)));

  a_r3_store_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opc == C_STA) |=> $stable(acc_q));

  a_r4_load_sext: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opc == C_LDI) |=>
      acc_q == {{(DATA_W-SEXT_W){$past(instr[SEXT_W-1])}}, $past(instr[SEXT_W-1:0])});

  a_r9_slt_is_bool: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opc == C_SLT) |=> acc_q[DATA_W-1:1] == '0);

  a_r11_port_copies_acc: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opc == C_OUT) |=> (out_data == $past(acc_q) && $stable(acc_q)));

  a_r11_port_holds: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opc != C_OUT) |=> $stable(out_data));

endmodule

bind accpu_top accpu_checks u_checks (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr       (instr),
  .instr_ready (instr_ready),
  .out_data    (out_data),
  .acc_q       (acc_q)
);

// File: tb/accpu_top_bench.sv
module accpu_top_bench;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] K_SLT = 4'h0, K_LDI = 4'h1, K_ADD = 4'h2, K_ADI = 4'h3,
                         K_STA = 4'h4, K_SUB = 4'h5, K_AND = 4'h6, K_OR  = 4'h7,
                         K_XOR = 4'h8, K_ANI = 4'h9, K_NOT = 4'hA, K_SLL = 4'hB,
                         K_SRL = 4'hC, K_SLI = 4'hD, K_SRI = 4'hE, K_OUT = 4'hF;

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [15:0] instr;
  logic        instr_ready;
  logic [7:0]  out_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accpu_top u_accpu_top (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .instr_ready (instr_ready),
    .out_data    (out_data)
  );

  function automatic logic [15:0] mk(input logic [3:0] op, input logic [1:0] rs,
                                     input logic [7:0] imm, input logic [1:0] rsv);
    return {op, rs, rsv, imm};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge, after commit.
  task automatic exec(input logic [15:0] w);
    instr = w;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic op(input logic [3:0] o, input logic [1:0] rs, input logic [7:0] imm);
    exec(mk(o, rs, imm, 2'b00));
  endtask

  task automatic show_acc(input logic [7:0] exp, input string what);
    op(K_OUT, 2'd0, 8'h00);
    check(out_data, exp, what);
  endtask

  task automatic read_reg(input logic [1:0] rs, input logic [7:0] exp, input string what);
    op(K_LDI, 2'd0, 8'h00);
    op(K_ADD, rs, 8'h00);
    show_acc(exp, what);
  endtask

  task automatic t_reset;
    rst = 1'b1; instr_valid = 1'b0; instr = '0;
    repeat (3) @(negedge clk);
    check({7'd0, instr_ready}, 8'h00, "R1 ready low in reset");
    check(out_data, 8'h00, "R1 port clear");
    rst = 1'b0;
    #1;
    check({7'd0, instr_ready}, 8'h01, "R1 ready high after reset");
    @(negedge clk);
    show_acc(8'h00, "R1 acc clear");
    read_reg(2'd1, 8'h00, "R1 x1 clear");
    read_reg(2'd3, 8'h00, "R1 x3 clear");
  endtask

  task automatic t_load;
    op(K_LDI, 2'd0, 8'h25);
    show_acc(8'hE5, "R4 load negative imm");
    op(K_LDI, 2'd0, 8'hDA);
    show_acc(8'h1A, "R4 imm bits 7:6 ignored");
  endtask

  task automatic t_addi;
    op(K_LDI, 2'd0, 8'h1F);
    op(K_ADI, 2'd0, 8'h3F);
    show_acc(8'h1E, "R5 add -1");
    op(K_LDI, 2'd0, 8'h20);
    op(K_ADI, 2'd0, 8'h20);
    show_acc(8'hC0, "R5 add negatives wrap");
  endtask

  task automatic t_store;
    op(K_LDI, 2'd0, 8'h05); op(K_STA, 2'd1, 8'h00);
    op(K_LDI, 2'd0, 8'h3A); op(K_STA, 2'd2, 8'h00);
    op(K_LDI, 2'd0, 8'h11); op(K_STA, 2'd3, 8'h00);
    op(K_STA, 2'd0, 8'h00);
    show_acc(8'h11, "R3 store keeps acc");
    op(K_LDI, 2'd0, 8'h07);
    op(K_OR, 2'd0, 8'h00);
    show_acc(8'h07, "R3 x0 reads zero after store to x0");
    read_reg(2'd1, 8'h05, "R3 x1 stored");
    read_reg(2'd2, 8'hFA, "R3 x2 stored");
    read_reg(2'd3, 8'h11, "R3 x3 stored");
  endtask

  // x1=0x05, x2=0xFA, x3=0x11 from here on
  task automatic t_reg_alu;
    op(K_LDI, 2'd0, 8'h03); op(K_ADD, 2'd2, 8'h00);
    show_acc(8'hFD, "R6 add register");
    op(K_SUB, 2'd1, 8'h00);
    show_acc(8'hF8, "R6 subtract register");
    op(K_LDI, 2'd0, 8'h00); op(K_SUB, 2'd1, 8'h00);
    show_acc(8'hFB, "R6 subtract wraps");
    op(K_LDI, 2'd0, 8'h1F); op(K_AND, 2'd2, 8'h00);
    show_acc(8'h1A, "R7 and");
    op(K_OR, 2'd3, 8'h00);
    show_acc(8'h1B, "R7 or");
    op(K_XOR, 2'd2, 8'h00);
    show_acc(8'hE1, "R7 xor");
  endtask

  task automatic t_ani_not;
    op(K_LDI, 2'd0, 8'h3F); op(K_ANI, 2'd0, 8'hA5);
    show_acc(8'hA5, "R8 and raw immediate");
    op(K_NOT, 2'd0, 8'h00);
    show_acc(8'h5A, "R8 complement");
  endtask

  task automatic t_slt;
    op(K_LDI, 2'd0, 8'h3F); op(K_SLT, 2'd1, 8'h00);
    show_acc(8'h01, "R9 -1 < 5");
    op(K_LDI, 2'd0, 8'h05); op(K_SLT, 2'd1, 8'h00);
    show_acc(8'h00, "R9 equal gives 0");
    op(K_LDI, 2'd0, 8'h1F); op(K_SLT, 2'd2, 8'h00);
    show_acc(8'h00, "R9 31 < -6 false");
    op(K_LDI, 2'd0, 8'h20); op(K_SLT, 2'd2, 8'h00);
    show_acc(8'h01, "R9 -32 < -6");
  endtask

  task automatic t_shift;
    op(K_LDI, 2'd0, 8'h2D); op(K_SLL, 2'd2, 8'h00);
    show_acc(8'hB4, "R10 shift left by register low bits");
    op(K_LDI, 2'd0, 8'h2D); op(K_SRL, 2'd2, 8'h00);
    show_acc(8'h3B, "R10 shift right by register low bits");
    op(K_LDI, 2'd0, 8'h2D); op(K_SLI, 2'd0, 8'hFB);
    show_acc(8'h68, "R10 shift left by imm");
    op(K_LDI, 2'd0, 8'h2D); op(K_SRI, 2'd0, 8'h0D);
    show_acc(8'h07, "R10 shift right by imm");
    op(K_LDI, 2'd0, 8'h2D); op(K_SLI, 2'd0, 8'h08);
    show_acc(8'hED, "R10 shift amount zero");
  endtask

  task automatic t_idle_and_hold;
    op(K_LDI, 2'd0, 8'h0A);
    show_acc(8'h0A, "R11 port loaded");
    op(K_LDI, 2'd0, 8'h15);
    check(out_data, 8'h0A, "R11 port holds across load");
    instr_valid = 1'b0;
    instr = mk(K_OUT, 2'd0, 8'h00, 2'b00);
    @(negedge clk);
    check(out_data, 8'h0A, "R2 idle output opcode ignored");
    instr = mk(K_STA, 2'd1, 8'h00, 2'b00);
    @(negedge clk);
    instr = mk(K_LDI, 2'd0, 8'h01, 2'b00);
    @(negedge clk);
    show_acc(8'h15, "R2 idle load ignored");
    read_reg(2'd1, 8'h05, "R2 idle store ignored");
  endtask

  task automatic t_reserved;
    exec(mk(K_LDI, 2'd0, 8'h02, 2'b11));
    exec(mk(K_ADD, 2'd1, 8'h00, 2'b11));
    exec(mk(K_STA, 2'd3, 8'h00, 2'b10));
    exec(mk(K_OUT, 2'd0, 8'h00, 2'b01));
    check(out_data, 8'h07, "R12 reserved bits ignored");
    read_reg(2'd3, 8'h07, "R12 register select field");
  endtask

  task automatic t_reset_collision;
    op(K_LDI, 2'd0, 8'h0B); op(K_STA, 2'd1, 8'h00);
    show_acc(8'h0B, "R1 setup");
    rst = 1'b1;
    exec(mk(K_STA, 2'd3, 8'h00, 2'b00));
    rst = 1'b0;
    check(out_data, 8'h00, "R1 port cleared by reset with valid");
    show_acc(8'h00, "R1 acc cleared by reset with valid");
    read_reg(2'd1, 8'h00, "R1 x1 cleared");
    read_reg(2'd3, 8'h00, "R1 reset beats store");
  endtask

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr = '0;
    @(negedge clk);
    t_reset();
    t_load();
    t_addi();
    t_store();
    t_reg_alu();
    t_ani_not();
    t_slt();
    t_shift();
    t_idle_and_hold();
    t_reserved();
    t_reset_collision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule